// File: doc/BRIEF.md
# Double-Buffered Serial Code Register for a DAC

This block is the digital front end of a serial-input digital-to-analog converter. A host shifts a code in, most significant bit first, over a three-wire port: a data pin, a serial clock pin and a load pin. A separate active-low clear pin also controls the block. Serial clock rising edges push bits into a staging shift register, but only while the load pin is high. When the load pin falls, the staging contents are copied into a holding register, and that holding register drives the converter code. A new value can therefore be staged while the converter keeps its present code.

All four pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one taken a cycle earlier. The code width is a parameter, normally 12 or 10. The clear pin always wins over the load pin. If clear is released while load is still low, the staged value is copied in at the release.

Top module: `sdac_input_regs`

## Requirements
- R1: After reset, `dac_code` is zero and the staging register is zero. A load falling edge with no bits shifted then leaves `dac_code` at zero.
- R2: On each synchronized rising edge of `ser_clk` while `ld_pin` is high, the staging register shifts left by one and takes `ser_dat` into bit 0. After exactly WIDTH pulses, the first bit sent sits in bit WIDTH-1.
- R3: When more than WIDTH bits are clocked in, only the last WIDTH bits are kept. For a 16-bit frame and WIDTH = 12, frame bits 15..12 have no effect and frame bits 11..0 become the code.
- R4: Rising edges of `ser_clk` while `ld_pin` is low do not change the staging register.
- R5: While bits are being shifted, `dac_code` keeps its previous value.
- R6: A high-to-low transition of `ld_pin` while `clr_n` is high copies the staging register into `dac_code`, no later than 3 system clock cycles after the transition.
- R7: While `clr_n` is low, `dac_code` is zero, and load falling edges do not transfer. Clear leaves the staging register untouched.
- R8: When `clr_n` rises while `ld_pin` is low, the staging register is copied into `dac_code`. When `clr_n` rises while `ld_pin` is high, `dac_code` stays zero.
- R9: Apart from R6, R7 and R8, `dac_code` holds its value from one system clock to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_dat | input | 1 | Serial data pin, asynchronous |
| ser_clk | input | 1 | Serial clock pin, asynchronous, shifts on rising edge |
| ld_pin | input | 1 | Load pin, asynchronous; high enables shifting, falling edge transfers |
| clr_n | input | 1 | Active-low clear pin, asynchronous |
| dac_code | output | WIDTH | Code held for the converter |

## Verification
The assertions observe the synchronized pin samples. They therefore assume that `ser_dat` is stable around each serial clock rising edge and that each pin level lasts several system clocks, so that the synchronizer never loses an edge. The stimulus changes data only while the serial clock is low and keeps every pin level for at least four system cycles. The stimulus also never moves two pins in the same cycle, except where clear and load ordering is the point of the test.

// File: rtl/sdac_pkg.sv
// Package: shared types and constants for the serial DAC code register.
// Assumes: pins are sampled into one packed struct so that all pins
// see the same synchronizer delay.
package sdac_pkg;

    localparam int DEF_WIDTH   = 12;
    localparam int SYNC_STAGES = 2;

    // One sample of the four control and data pins.
    typedef struct packed {
        logic sclk;
        logic load;
        logic clr_n;
        logic sdat;
    } pin_t;

    localparam int PIN_BITS = $bits(pin_t);

    // Idle level of each pin, used as the synchronizer reset value so that
    // leaving reset produces no false edge.
    localparam pin_t PIN_IDLE = '{sclk: 1'b0, load: 1'b1, clr_n: 1'b1, sdat: 1'b0};

    // Edge events detected on the synchronized pins.
    typedef struct packed {
        logic sclk_rise;
        logic load_fall;
        logic clr_rise;
    } evt_t;

endpackage

// File: rtl/sdac_sync.sv
// Module: multi-bit, multi-stage synchronizer.
// Each bit passes through its own chain of STAGES flops. The bits are
// independent, so a group of bits is only coherent once they are stable.
// Assumes: synchronous active-low reset; RST_VAL is the idle level.
module sdac_sync #(
    parameter int              BITS    = 4,
    parameter int              STAGES  = 2,
    parameter logic [BITS-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] d_async,
    output logic [BITS-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < BITS; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous bit through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else if (STAGES > 1) begin
                chain <= {chain[STAGES-2:0], d_async[b]};
            end else begin
                chain <= d_async[b];
            end
        end

        assign q_sync[b] = chain[LAST];
    end

endmodule

// File: rtl/sdac_edges.sv
// Module: edge detector for the synchronized serial clock, load and clear.
// It keeps the previous sample of each pin and flags the edges the
// register logic acts on.
// Assumes: inputs are already synchronized to clk.
module sdac_edges
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic load_s,
    input  logic clr_n_s,
    output evt_t evt
);

    logic sclk_q, load_q, clr_n_q;

    // Remember the previous synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= PIN_IDLE.sclk;
            load_q  <= PIN_IDLE.load;
            clr_n_q <= PIN_IDLE.clr_n;
        end else begin
            sclk_q  <= sclk_s;
            load_q  <= load_s;
            clr_n_q <= clr_n_s;
        end
    end

    // Compare the current and previous samples to find edges.
    always_comb begin
        evt.sclk_rise = sclk_s & ~sclk_q;
        evt.load_fall = load_q & ~load_s;
        evt.clr_rise  = clr_n_s & ~clr_n_q;
    end

endmodule

// File: rtl/sdac_shifter.sv
// Module: staging shift register, MSB first.
// Each accepted serial clock edge shifts left and brings the data bit into
// bit 0, so the oldest bits fall off the top and the last WIDTH bits stay.
// Assumes: shift_en is a one-cycle pulse per accepted serial clock edge.
module sdac_shifter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] stage
);

    // Shift in one bit per accepted edge; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (shift_en) begin
            stage <= {stage[WIDTH-2:0], bit_in};
        end
    end

endmodule

// File: rtl/sdac_holdreg.sv
// Module: holding register that drives the converter code.
// Clear has top priority and forces zero. Otherwise a load falling edge, or
// a clear release while load is low, copies the staged value.
// Assumes: event inputs are single-cycle pulses from sdac_edges.
module sdac_holdreg
    import sdac_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n_s,
    input  logic             load_s,
    input  evt_t             evt,
    input  logic [WIDTH-1:0] stage,
    output logic [WIDTH-1:0] code
);

    logic take;

    // Decide whether the staged value is copied this cycle.
    always_comb begin
        take = evt.load_fall | (evt.clr_rise & ~load_s);
    end

    // Update the held code: clear first, then transfer, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (!clr_n_s) begin
            code <= '0;
        end else if (take) begin
            code <= stage;
        end
    end

endmodule

// File: rtl/sdac_input_regs.sv
// Module: top level of the double-buffered serial code register.
// It synchronizes the pins, detects edges, stages serial bits and holds
// the converter code.
// Assumes: clk runs at least 4x the serial clock rate; data is stable
// around each serial clock rising edge.
module sdac_input_regs
    import sdac_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_dat,
    input  logic             ser_clk,
    input  logic             ld_pin,
    input  logic             clr_n,
    output logic [WIDTH-1:0] dac_code
);

    pin_t             pins_a;
    pin_t             pins_s;
    evt_t             evt;
    logic             shift_en;
    logic [WIDTH-1:0] stage;

    // Gather the asynchronous pins into one sample.
    always_comb begin
        pins_a.sclk  = ser_clk;
        pins_a.load  = ld_pin;
        pins_a.clr_n = clr_n;
        pins_a.sdat  = ser_dat;
    end

    sdac_sync #(
        .BITS    (PIN_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_a),
        .q_sync  (pins_s)
    );

    sdac_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s.sclk),
        .load_s  (pins_s.load),
        .clr_n_s (pins_s.clr_n),
        .evt     (evt)
    );

    // Serial clock edges are honoured only while load is high.
    always_comb begin
        shift_en = evt.sclk_rise & pins_s.load;
    end

    sdac_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (pins_s.sdat),
        .stage    (stage)
    );

    sdac_holdreg #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n_s (pins_s.clr_n),
        .load_s  (pins_s.load),
        .evt     (evt),
        .stage   (stage),
        .code    (dac_code)
    );

endmodule

// File: rtl/sdac_input_regs_chk.sv
// Checker: temporal properties of the serial code register, bound to the top.
module sdac_input_regs_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_s,
    input logic             load_s,
    input logic             clr_n_s,
    input logic             sdat_s,
    input logic             load_fall,
    input logic             clr_rise,
    input logic [WIDTH-1:0] stage,
    input logic [WIDTH-1:0] dac_code
);

    AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !$past(sclk_s) && load_s) |=> (stage[0] == $past(sdat_s))); // R2

    AST_NO_SHIFT_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_s) |=> $stable(stage)); // R4

    AST_LOAD_FALL_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && clr_n_s) |=> (dac_code == $past(stage))); // R6

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n_s) |=> (dac_code == '0)); // R7

    AST_RELEASE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !load_s) |=> (dac_code == $past(stage))); // R8

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_s && !load_fall && !(clr_rise && !load_s)) |=> $stable(dac_code)); // R9

endmodule

bind sdac_input_regs sdac_input_regs_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s.sclk),
    .load_s    (pins_s.load),
    .clr_n_s   (pins_s.clr_n),
    .sdat_s    (pins_s.sdat),
    .load_fall (evt.load_fall),
    .clr_rise  (evt.clr_rise),
    .stage     (stage),
    .dac_code  (dac_code)
);

// File: tb/sdac_input_regs_test.sv
module sdac_input_regs_test;

    localparam int W  = 12;
    localparam int NV = 7;

    // Stimulus table: frame bits (sent MSB first from bit len-1), length,
    // expected code after the load falling edge.
    localparam logic [15:0] V_FRAME [NV] = '{16'h0ABC, 16'h0000, 16'h0FFF,
                                             16'hF123, 16'h8001, 16'h0800, 16'h5A5A};
    localparam int          V_LEN   [NV] = '{12, 12, 12, 16, 16, 12, 16};
    localparam logic [11:0] V_EXP   [NV] = '{12'hABC, 12'h000, 12'hFFF,
                                             12'h123, 12'h001, 12'h800, 12'hA5A};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_dat = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ld_pin = 1'b1;
    logic         clr_n = 1'b1;
    logic [W-1:0] dac_code;

    int n_chk  = 0;
    int n_fail = 0;

    sdac_input_regs #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_dat  (ser_dat),
        .ser_clk  (ser_clk),
        .ld_pin   (ld_pin),
        .clr_n    (clr_n),
        .dac_code (dac_code)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        tick(4);
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic send_frame(input logic [15:0] f, input int len);
        for (int i = len - 1; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_load();
        ld_pin = 1'b0;
        tick(6);
        ld_pin = 1'b1;
        tick(6);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        tick(200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] prev;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        check("R1 reset code", dac_code, 0);
        pulse_load();
        check("R1 staging zero after reset", dac_code, 0);

        // Table walk: R2, R3 (upper frame bits ignored), R5, R6.
        prev = dac_code;
        for (int v = 0; v < NV; v++) begin
            send_frame(V_FRAME[v], V_LEN[v]);
            check("R5 code held while shifting", dac_code, prev);
            ld_pin = 1'b0;
            tick(4);
            check(V_LEN[v] > W ? "R3 last bits kept" : "R2/R6 transfer", dac_code, V_EXP[v]);
            ld_pin = 1'b1;
            tick(6);
            prev = V_EXP[v];
        end

        // R4: clocks while load low do not shift.
        ld_pin = 1'b0;
        tick(6);
        send_frame(16'h0F0F, 12);
        ld_pin = 1'b1;
        tick(6);
        pulse_load();
        check("R4 no shift while load low", dac_code, 12'hA5A);

        // R7: clear forces zero and overrides load.
        send_frame(16'h0321, 12);
        clr_n = 1'b0;
        tick(4);
        check("R7 clear to zero", dac_code, 0);
        pulse_load();
        check("R7 clear overrides load", dac_code, 0);
        clr_n = 1'b1;
        tick(6);
        check("R8 release with load high keeps zero", dac_code, 0);
        pulse_load();
        check("R7 staging kept through clear", dac_code, 12'h321);

        // R8: release while load low transfers.
        send_frame(16'h05A3, 12);
        clr_n = 1'b0;
        tick(6);
        ld_pin = 1'b0;
        tick(6);
        check("R7 load fall ignored under clear", dac_code, 0);
        clr_n = 1'b1;
        tick(4);
        check("R8 release with load low transfers", dac_code, 12'h5A3);
        ld_pin = 1'b1;
        tick(6);
        check("R9 code stable after load rise", dac_code, 12'h5A3);

        // R1 again: reset mid-run clears code.
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        check("R1 code after second reset", dac_code, 0);
        finish_run();
    end

endmodule